// File: doc/BRIEF.md
# SPI Master Controller with FIFO Flow Control

This block is a register-mapped SPI master. A host writes configuration and transmit words through a simple single-cycle register port and reads received words and status back through the same port. A 32-entry transmit FIFO and a 32-entry receive FIFO sit between the registers and a shift engine. The engine produces the serial clock, the MOSI data and the active-low chip selects, and it samples MISO. It runs a programmed number of frames, each 8 or 16 bits long, in any of the four clock polarity and phase combinations.

Flow control is built into the engine. A frame only begins when the transmit FIFO holds a word (in the modes that send data) and the receive FIFO has a free slot (in the modes that keep data). Otherwise the serial clock is frozen at its idle level between frames until the host catches up, so no word is ever dropped or invented. In receive-only mode the engine clocks the whole programmed count without any transmit writes and holds MOSI low. Clearing the enable register aborts the transfer and empties both FIFOs.

Register addresses: 0 control, 1 frame count, 2 enable, 3 chip select, 4 clock divider, 5 transmit data (write), 6 receive data (read, pops), 7 transmit level, 8 receive level, 9 status. Unmapped addresses read as zero.

Top module: `spim_top`

## Requirements
- R1: After reset, status reads 0x4, both level registers read 0, the divider reads 2, the frame count, control and enable registers read 0, every chip select is high and SCLK and MOSI are low.
- R2: The serial clock half period is divider/2 input clock cycles (divider bit 0 ignored). A divider below 2 behaves as 2.
- R3: The frame count register holds the number of frames minus one. Exactly that many frames are shifted, after which the busy flag clears.
- R4: Each FIFO holds 32 words. The level registers report the current occupancy, and a transmit write to a full FIFO is discarded.
- R5: No frame starts while the receive FIFO holds 32 words in a receiving mode. The engine resumes once the host reads, and every frame is delivered.
- R6: In a transmitting mode no frame starts while the transmit FIFO is empty. SCLK stays idle and busy stays high until data arrives.
- R7: Enable (bit 0 of address 2) gates the engine. Clearing it stops the transfer, returns SCLK to idle and empties both FIFOs. Transmit writes while disabled are discarded, and a transfer begins only after enable is set.
- R8: The chip select register accepts a one-hot value or zero. Writing 1<<n drives csN[n] low, writing 0 releases all selects, and any other value is ignored.
- R9: Status bit 0 is busy, bit 1 is transmit FIFO full and bit 2 is receive FIFO empty.
- R10: Control bits [4:3] choose the mode. 0 (and 3) means full duplex, 1 means transmit only with nothing written to the receive FIFO, and 2 means receive only with MOSI driven low and no transmit data needed.
- R11: Control bit 2 selects 16-bit frames, and clear selects 8-bit frames using the low byte. Bits go out and come in MSB first.
- R12: Control bit 0 (CPOL) sets the idle SCLK level. Control bit 1 (CPHA) chooses sampling on the first edge (clear) or the second edge (set) of each bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (pops at the receive data address) |
| addr | input | 4 | Register address |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data, combinational from addr |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | NUM_CS | Active-low chip selects |

## Verification
The main function is swept over every CPOL, CPHA and frame size combination with three divider settings, using MOSI looped back to MISO. An observer on the serial lines reassembles words on the sampling edges, which separates the bit order, the edge choice and the clock rate from one another, while the looped-back receive data confirms the capture edge independently. Dedicated patterns starve the transmit FIFO and flood the receive FIFO: frozen edge counts during a stall separate real flow control from silent data loss or zero fill. Receive-only runs with MISO held high separate the narrow frame mask from the wide one.

// File: rtl/spim_pkg.sv
package spim_pkg;

  localparam int REG_W        = 16;
  localparam int ADDR_W       = 4;
  localparam int FRAME_WIDE   = 16;
  localparam int FRAME_NARROW = 8;
  localparam int BIT_IDX_W    = $clog2(FRAME_WIDE);
  localparam int EDGE_W       = $clog2(2 * FRAME_WIDE);

  localparam logic [ADDR_W-1:0] RA_CTRL    = 4'd0;
  localparam logic [ADDR_W-1:0] RA_FRAMES  = 4'd1;
  localparam logic [ADDR_W-1:0] RA_ENABLE  = 4'd2;
  localparam logic [ADDR_W-1:0] RA_SELECT  = 4'd3;
  localparam logic [ADDR_W-1:0] RA_DIVIDER = 4'd4;
  localparam logic [ADDR_W-1:0] RA_TXDATA  = 4'd5;
  localparam logic [ADDR_W-1:0] RA_RXDATA  = 4'd6;
  localparam logic [ADDR_W-1:0] RA_TXLEVEL = 4'd7;
  localparam logic [ADDR_W-1:0] RA_RXLEVEL = 4'd8;
  localparam logic [ADDR_W-1:0] RA_STATUS  = 4'd9;

  typedef enum logic [1:0] {
    XFER_DUPLEX = 2'd0,
    XFER_TXONLY = 2'd1,
    XFER_RXONLY = 2'd2
  } xferMode_e;

  typedef struct packed {
    logic cpol;
    logic cpha;
    logic wide;
  } frameCfg_t;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic flush;
    logic idle;
    logic loadFrame;
    logic popTx;
    logic edgeHit;
    logic lead;
    logic lastEdge;
    logic pushRx;
    logic pushTx;
    logic popRx;
  } engStrobe_t;

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         flush,
  input  logic                         push,
  input  logic [WIDTH-1:0]             pushData,
  input  logic                         pop,
  output logic [WIDTH-1:0]             headData,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             doPush, doPop;

  assign doPush   = push && (level != LVL_W'(DEPTH));
  assign doPop    = pop && (level != '0);
  assign headData = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (doPush && !flush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop)      level <= level + LVL_W'(1);
      else if (doPop && !doPush) level <= level - LVL_W'(1);
    end
  end
endmodule

// File: rtl/spim_datapath.sv
module spim_datapath
  import spim_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  engStrobe_t                 stb,
  input  frameCfg_t                  cfg,
  input  logic [REG_W-1:0]           wdata,
  input  logic                       miso,
  output logic                       sclk,
  output logic                       mosi,
  output logic [$clog2(DEPTH+1)-1:0] txLevel,
  output logic [$clog2(DEPTH+1)-1:0] rxLevel,
  output logic [REG_W-1:0]           rxHead
);
  logic [REG_W-1:0]     txHead, txWord, rxShift, rxNext, loadWord;
  logic [BIT_IDX_W-1:0] outIdx, topIdx;
  logic                 driveEdge, sampleEdge;

  spim_fifo #(.WIDTH(REG_W), .DEPTH(DEPTH)) u_txFifo (
    .clk(clk), .rstN(rstN), .flush(stb.flush),
    .push(stb.pushTx), .pushData(wdata),
    .pop(stb.popTx), .headData(txHead), .level(txLevel)
  );

  spim_fifo #(.WIDTH(REG_W), .DEPTH(DEPTH)) u_rxFifo (
    .clk(clk), .rstN(rstN), .flush(stb.flush),
    .push(stb.pushRx), .pushData(rxNext),
    .pop(stb.popRx), .headData(rxHead), .level(rxLevel)
  );

  assign topIdx     = cfg.wide ? BIT_IDX_W'(FRAME_WIDE - 1) : BIT_IDX_W'(FRAME_NARROW - 1);
  assign loadWord   = stb.popTx ? txHead : '0;
  // CPHA=0: data changes on trailing edges, sampled on leading ones; CPHA=1 swaps them.
  assign driveEdge  = stb.edgeHit && !stb.lastEdge && (cfg.cpha ? stb.lead : !stb.lead);
  assign sampleEdge = stb.edgeHit && (cfg.cpha ? !stb.lead : stb.lead);
  assign rxNext     = sampleEdge ? {rxShift[REG_W-2:0], miso} : rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclk    <= 1'b0;
      mosi    <= 1'b0;
      txWord  <= '0;
      rxShift <= '0;
      outIdx  <= '0;
    end else if (stb.idle) begin
      sclk <= cfg.cpol;
      mosi <= 1'b0;
    end else if (stb.loadFrame) begin
      txWord  <= loadWord;
      rxShift <= '0;
      if (!cfg.cpha) begin
        mosi   <= loadWord[topIdx];
        outIdx <= topIdx - BIT_IDX_W'(1);
      end else begin
        outIdx <= topIdx;
      end
    end else begin
      if (stb.edgeHit) sclk <= ~sclk;
      if (driveEdge) begin
        mosi   <= txWord[outIdx];
        outIdx <= outIdx - BIT_IDX_W'(1);
      end
      rxShift <= rxNext;
    end
  end
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int NUM_CS = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic                       rdEn,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [REG_W-1:0]           wdata,
  output logic [REG_W-1:0]           rdata,
  input  logic [$clog2(DEPTH+1)-1:0] txLevel,
  input  logic [$clog2(DEPTH+1)-1:0] rxLevel,
  input  logic [REG_W-1:0]           rxHead,
  output frameCfg_t                  cfg,
  output engStrobe_t                 stb,
  output logic                       busy,
  output logic                       enable,
  output logic [NUM_CS-1:0]          csN
);
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int HALF_W = REG_W - 1;
  localparam logic [REG_W-1:0] CS_MASK = REG_W'((32'd1 << NUM_CS) - 1);
  localparam logic [EDGE_W-1:0] LAST_WIDE   = EDGE_W'(2 * FRAME_WIDE - 1);
  localparam logic [EDGE_W-1:0] LAST_NARROW = EDGE_W'(2 * FRAME_NARROW - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SHIFT, ST_DONE} engState_e;

  engState_e           state;
  logic [1:0]          modeR;
  logic                cpolR, cphaR, wideR, enR;
  logic [REG_W-1:0]    frameReg, frameLeft, divR;
  logic [NUM_CS-1:0]   selR;
  logic [HALF_W-1:0]   halfLim, halfCnt;
  logic [EDGE_W-1:0]   edgeCnt, lastIdx;
  logic                needTx, needRx, canLoad, edgeHit, lastEdge, txFull, rxEmpty;

  assign cfg     = '{cpol: cpolR, cpha: cphaR, wide: wideR};
  assign enable  = enR;
  assign csN     = ~selR;
  assign busy    = (state == ST_LOAD) || (state == ST_SHIFT);
  assign needTx  = (modeR != XFER_RXONLY);
  assign needRx  = (modeR != XFER_TXONLY);
  assign txFull  = (txLevel == LVL_W'(DEPTH));
  assign rxEmpty = (rxLevel == '0);
  assign halfLim = (divR[REG_W-1:1] == '0) ? HALF_W'(1) : divR[REG_W-1:1];
  assign lastIdx = wideR ? LAST_WIDE : LAST_NARROW;

  assign canLoad  = (state == ST_LOAD) && (!needTx || (txLevel != '0))
                    && (!needRx || (rxLevel < LVL_W'(DEPTH)));
  assign edgeHit  = (state == ST_SHIFT) && (halfCnt == halfLim - HALF_W'(1));
  assign lastEdge = edgeHit && (edgeCnt == lastIdx);

  always_comb begin
    stb           = '0;
    stb.flush     = !enR;
    stb.idle      = !busy;
    stb.loadFrame = canLoad;
    stb.popTx     = canLoad && needTx;
    stb.edgeHit   = edgeHit;
    stb.lead      = !edgeCnt[0];
    stb.lastEdge  = lastEdge;
    stb.pushRx    = lastEdge && needRx;
    stb.pushTx    = wrEn && (addr == RA_TXDATA) && enR;
    stb.popRx     = rdEn && (addr == RA_RXDATA);
  end

  // Register writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {modeR, wideR, cphaR, cpolR} <= '0;
      frameReg <= '0;
      enR      <= 1'b0;
      selR     <= '0;
      divR     <= REG_W'(2);
    end else if (wrEn) begin
      case (addr)
        RA_CTRL:    {modeR, wideR, cphaR, cpolR} <= wdata[4:0];
        RA_FRAMES:  frameReg <= wdata;
        RA_ENABLE:  enR <= wdata[0];
        RA_SELECT:  if ($onehot0(wdata) && ((wdata & ~CS_MASK) == '0))
                      selR <= wdata[NUM_CS-1:0];
        RA_DIVIDER: divR <= wdata;
        default: ;
      endcase
    end
  end

  // Transfer sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      frameLeft <= '0;
      halfCnt   <= '0;
      edgeCnt   <= '0;
    end else if (!enR) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: begin
          state     <= ST_LOAD;
          frameLeft <= frameReg;
        end
        ST_LOAD: if (canLoad) begin
          state   <= ST_SHIFT;
          halfCnt <= '0;
          edgeCnt <= '0;
        end
        ST_SHIFT: begin
          if (edgeHit) begin
            halfCnt <= '0;
            edgeCnt <= edgeCnt + EDGE_W'(1);
            if (lastEdge) begin
              if (frameLeft == '0) state <= ST_DONE;
              else begin
                frameLeft <= frameLeft - REG_W'(1);
                state     <= ST_LOAD;
              end
            end
          end else begin
            halfCnt <= halfCnt + HALF_W'(1);
          end
        end
        default: state <= ST_DONE;
      endcase
    end
  end

  // Register reads
  always_comb begin
    case (addr)
      RA_CTRL:    rdata = REG_W'({modeR, wideR, cphaR, cpolR});
      RA_FRAMES:  rdata = frameReg;
      RA_ENABLE:  rdata = REG_W'(enR);
      RA_SELECT:  rdata = REG_W'(selR);
      RA_DIVIDER: rdata = divR;
      RA_RXDATA:  rdata = rxEmpty ? '0 : rxHead;
      RA_TXLEVEL: rdata = REG_W'(txLevel);
      RA_RXLEVEL: rdata = REG_W'(rxLevel);
      RA_STATUS:  rdata = REG_W'({rxEmpty, txFull, busy});
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/spim_top.sv
module spim_top
  import spim_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int NUM_CS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [3:0]        addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] csN
);
  engStrobe_t                 stb;
  frameCfg_t                  cfg;
  logic [$clog2(DEPTH+1)-1:0] txLevel, rxLevel;
  logic [REG_W-1:0]           rxHead;
  logic                       busy, enable;

  spim_ctrl #(.DEPTH(DEPTH), .NUM_CS(NUM_CS)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .txLevel(txLevel), .rxLevel(rxLevel),
    .rxHead(rxHead), .cfg(cfg), .stb(stb), .busy(busy), .enable(enable),
    .csN(csN)
  );

  spim_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cfg(cfg), .wdata(wdata),
    .miso(miso), .sclk(sclk), .mosi(mosi), .txLevel(txLevel),
    .rxLevel(rxLevel), .rxHead(rxHead)
  );
endmodule

// File: rtl/spim_checker.sv
module spim_checker #(
  parameter int DEPTH  = 32,
  parameter int NUM_CS = 4
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       pushRx,
  input logic                       popTx,
  input logic                       edgeHit,
  input logic                       cpol,
  input logic                       busy,
  input logic                       enable,
  input logic                       sclk,
  input logic [NUM_CS-1:0]          csN,
  input logic [$clog2(DEPTH+1)-1:0] txLevel,
  input logic [$clog2(DEPTH+1)-1:0] rxLevel
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    pushRx |-> (rxLevel < LVL_W'(DEPTH)));

  assert_no_underrun_R6: assert property (@(posedge clk) disable iff (!rstN)
    popTx |-> (txLevel != '0));

  assert_flush_empty_R7: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (txLevel == '0) && (rxLevel == '0));

  assert_disable_stops_R7: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !busy);

  assert_select_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));

  assert_sclk_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !edgeHit) |=> $stable(sclk));

  assert_sclk_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy) && $stable(cpol)) |-> (sclk == cpol));
endmodule

bind spim_top spim_checker #(.DEPTH(DEPTH), .NUM_CS(NUM_CS)) u_spimChecker (
  .clk(clk), .rstN(rstN), .pushRx(stb.pushRx), .popTx(stb.popTx),
  .edgeHit(stb.edgeHit), .cpol(cfg.cpol), .busy(busy), .enable(enable),
  .sclk(sclk), .csN(csN), .txLevel(txLevel), .rxLevel(rxLevel)
);

// File: tb/test_spim_top.sv
module test_spim_top;
  import spim_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic        sclk, mosi, miso;
  logic [3:0]  csN;
  logic        loopback = 1'b1, misoForce = 1'b0;

  int checks = 0, fails = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;
  assign miso = loopback ? mosi : misoForce;

  spim_top i_spim_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sclk(sclk), .mosi(mosi), .miso(miso),
    .csN(csN)
  );

  // Serial line observer
  logic        monClear = 1'b0, monCpol = 1'b0, monCpha = 1'b0;
  int          monFrameBits = 8;
  logic [15:0] monQ [64];
  logic [15:0] monWord = '0;
  logic        sclkPrev = 1'b0;
  int monCnt = 0, bitCnt = 0, edgeTotal = 0, minGap = 0, cyc = 0, lastEdgeCyc = 0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (monClear) begin
      monCnt = 0; bitCnt = 0; edgeTotal = 0; minGap = 1000000;
      lastEdgeCyc = cyc; monWord = '0; sclkPrev = sclk;
    end else if (rstN && (sclk !== sclkPrev)) begin
      if (cyc - lastEdgeCyc < minGap) minGap = cyc - lastEdgeCyc;
      lastEdgeCyc = cyc;
      edgeTotal = edgeTotal + 1;
      if (monCpha ? (sclkPrev != monCpol) : (sclkPrev == monCpol)) begin
        monWord = {monWord[14:0], mosi};
        bitCnt = bitCnt + 1;
        if (bitCnt == monFrameBits) begin
          if (monCnt < 64) monQ[monCnt] = monWord;
          monCnt = monCnt + 1;
          bitCnt = 0;
          monWord = '0;
        end
      end
      sclkPrev = sclk;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic busPop(output logic [15:0] d);
    @(negedge clk); addr = RA_RXDATA; rdEn = 1'b1; #1 d = rdata;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic waitIdle();
    logic [15:0] s;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 60000; i++) begin
      busRead(RA_STATUS, s);
      if (!s[0]) break;
    end
  endtask

  task automatic setup(input logic cpol, input logic cpha, input logic wide,
                       input logic [1:0] mode, input logic [15:0] div,
                       input logic [15:0] frames);
    busWrite(RA_ENABLE, 16'h0);
    busWrite(RA_CTRL, {11'h0, mode, wide, cpha, cpol});
    busWrite(RA_DIVIDER, div);
    busWrite(RA_FRAMES, frames);
    @(posedge clk);
    monCpol = cpol; monCpha = cpha; monFrameBits = wide ? 16 : 8; monClear = 1'b1;
    @(posedge clk);
    monClear = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog R3: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails + 1);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    logic [15:0] words [3];
    int cfgIdx;

    repeat (4) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1 reset state
    busRead(RA_STATUS, r);  check("R1 status", r, 16'h4);
    busRead(RA_TXLEVEL, r); check("R1 txLevel", r, 0);
    busRead(RA_RXLEVEL, r); check("R1 rxLevel", r, 0);
    busRead(RA_DIVIDER, r); check("R1 divider", r, 2);
    busRead(RA_FRAMES, r);  check("R1 frames", r, 0);
    busRead(RA_CTRL, r);    check("R1 ctrl", r, 0);
    busRead(RA_ENABLE, r);  check("R1 enable", r, 0);
    check("R1 csN", csN, 4'hF);
    check("R1 sclk/mosi", {sclk, mosi}, 2'b00);

    // R8 chip select
    busWrite(RA_SELECT, 16'h0004); check("R8 select 2", csN, 4'b1011);
    busWrite(RA_SELECT, 16'h0003); check("R8 non-onehot ignored", csN, 4'b1011);
    busWrite(RA_SELECT, 16'h0100); check("R8 out-of-range ignored", csN, 4'b1011);
    busWrite(RA_SELECT, 16'h0000); check("R8 release", csN, 4'hF);

    // Sweep of modes, sizes and dividers in duplex loopback (R2 R3 R10 R11 R12)
    cfgIdx = 0;
    loopback = 1'b1;
    for (int pol = 0; pol < 2; pol++) begin
      for (int pha = 0; pha < 2; pha++) begin
        for (int wd = 0; wd < 2; wd++) begin
          for (int dv = 0; dv < 3; dv++) begin
            automatic logic [15:0] div = (dv == 0) ? 16'd0 : ((dv == 1) ? 16'd2 : 16'd6);
            automatic int expGap = (div < 2) ? 1 : int'(div) / 2;
            setup(pol[0], pha[0], wd[0], 2'd0, div, 16'd2);
            check("R12 idle level", sclk, pol[0]);
            busWrite(RA_ENABLE, 16'h1);
            for (int k = 0; k < 3; k++) begin
              words[k] = 16'hB4D1 ^ 16'(k * 16'h2F17) ^ 16'(cfgIdx * 16'h0C39);
              if (wd == 0) words[k][15:8] = 8'h00;
              busWrite(RA_TXDATA, words[k] ^ (wd == 0 ? 16'h5A00 : 16'h0000));
            end
            waitIdle();
            check("R3 frame count", monCnt, 3);
            for (int k = 0; k < 3; k++) begin
              check("R11 R12 MOSI word", monQ[k], words[k]);
              busPop(r);
              check("R10 duplex receive", r, words[k]);
            end
            check("R2 half period", minGap, expGap);
            check("R12 sclk idle after", sclk, pol[0]);
            cfgIdx++;
          end
        end
      end
    end

    // R6 transmit starvation, transmit-only mode (R10)
    setup(1'b1, 1'b1, 1'b0, 2'd1, 16'd4, 16'd2);
    busWrite(RA_ENABLE, 16'h1);
    busWrite(RA_TXDATA, 16'h005A);
    repeat (300) @(negedge clk);
    busRead(RA_STATUS, r);
    check("R6 busy while starved", r[0], 1'b1);
    check("R6 edges frozen", edgeTotal, 16);
    check("R6 one frame out", monCnt, 1);
    check("R6 sclk idle while starved", sclk, 1'b1);
    busWrite(RA_TXDATA, 16'h003C);
    busWrite(RA_TXDATA, 16'h0081);
    waitIdle();
    check("R6 all frames", monCnt, 3);
    check("R6 word0", monQ[0], 16'h5A);
    check("R6 word1", monQ[1], 16'h3C);
    check("R6 word2", monQ[2], 16'h81);
    busRead(RA_RXLEVEL, r);
    check("R10 tx-only keeps no data", r, 0);

    // R5 receive overflow protection, receive-only (R10)
    loopback = 1'b0; misoForce = 1'b1;
    setup(1'b0, 1'b0, 1'b0, 2'd2, 16'd2, 16'd39);
    busWrite(RA_ENABLE, 16'h1);
    repeat (2000) @(negedge clk);
    busRead(RA_RXLEVEL, r); check("R5 receive full", r, 32);
    busRead(RA_STATUS, r);  check("R9 R5 status busy not empty", r, 16'h1);
    check("R5 edges frozen", edgeTotal, 32 * 16);
    busRead(RA_TXLEVEL, r); check("R10 rx-only no tx", r, 0);
    for (int k = 0; k < 32; k++) begin
      busPop(r);
      check("R5 R11 narrow rx word", r, 16'h00FF);
    end
    waitIdle();
    check("R5 total frames", monCnt, 40);
    busRead(RA_RXLEVEL, r); check("R5 remainder", r, 8);
    for (int k = 0; k < 8; k++) begin
      busPop(r);
      check("R5 remainder word", r, 16'h00FF);
    end
    for (int k = 0; k < 32; k++) begin
      check("R10 MOSI low in rx-only", monQ[k], 16'h0);
    end
    busRead(RA_STATUS, r); check("R9 idle empty", r, 16'h4);

    // R11 wide receive-only
    setup(1'b1, 1'b0, 1'b1, 2'd2, 16'd4, 16'd1);
    busWrite(RA_ENABLE, 16'h1);
    waitIdle();
    busPop(r); check("R11 wide rx word0", r, 16'hFFFF);
    busPop(r); check("R11 wide rx word1", r, 16'hFFFF);
    loopback = 1'b1;

    // R4 transmit FIFO full, R9 full flag, R7 flush
    setup(1'b0, 1'b0, 1'b1, 2'd0, 16'hFFFE, 16'd100);
    busWrite(RA_ENABLE, 16'h1);
    for (int k = 0; k < 34; k++) busWrite(RA_TXDATA, 16'(k));
    busRead(RA_TXLEVEL, r); check("R4 tx capacity", r, 32);
    busRead(RA_STATUS, r);  check("R9 full busy empty", r, 16'h7);
    busWrite(RA_ENABLE, 16'h0);
    busRead(RA_TXLEVEL, r); check("R7 tx flushed", r, 0);
    busRead(RA_STATUS, r);  check("R7 stopped", r, 16'h4);
    check("R7 sclk idle", sclk, 1'b0);
    busWrite(RA_TXDATA, 16'h1234);
    busRead(RA_TXLEVEL, r); check("R7 write while disabled", r, 0);

    // R7 receive flush
    setup(1'b0, 1'b1, 1'b0, 2'd0, 16'd2, 16'd1);
    busWrite(RA_ENABLE, 16'h1);
    busWrite(RA_TXDATA, 16'h11);
    busWrite(RA_TXDATA, 16'h22);
    waitIdle();
    busRead(RA_RXLEVEL, r); check("R4 rx level", r, 2);
    busWrite(RA_ENABLE, 16'h0);
    busRead(RA_RXLEVEL, r); check("R7 rx flushed", r, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule